// File: doc/BRIEF.md
# Bulk CPU State Load Sequencer

This block restores the entire register state of a small 16-bit CPU model from one memory table in a single operation. It watches the instruction byte stream. When the two-byte trigger opcode arrives, it reads 51 consecutive 16-bit words from a table at a fixed, hard-wired address. It places each word into the matching architectural register, selector, segment descriptor cache or system table register. Unused table slots are read and then dropped.

Reads use a word-wide request/acknowledge port. The request stays up, and the address stays put, until the word is acknowledged. The next address goes out on the following cycle. When the last word has been taken, the block pulses `done` for one cycle. At that point `fetch_addr` gives the resume point: the code-segment cache base plus the loaded instruction pointer. Interrupts are held off for the whole operation. Decode beyond the trigger, protection checks and the execution pipeline are not part of this block.

Top module: `state_restore_seq`

## Requirements
- R1: Two valid bytes, 0x0F and then 0x05, with no other valid byte between them start a load when the block is idle. Cycles with `op_valid` low do not break the pair. Any other valid byte between them cancels the pair. Bytes that arrive while a load is running are ignored and start no further load.
- R2: A load reads exactly 51 words, at byte addresses 0x000800 + 2k for k = 0 to 50, in ascending order. The base address is fixed.
- R3: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. After an acknowledge that is not the last, the next word is requested on the very next cycle.
- R4: Word k lands as follows (k = 0 is the first word):
  - Word 3: bits [3:0] go to `msw` (bit 0 protected-mode enable, bit 1 monitor, bit 2 emulate, bit 3 task-switched). Its upper 12 bits are discarded.
  - Word 11 goes to `task_reg`, word 12 to `flags`, word 13 to `ip` and word 14 to `ldt_sel`.
  - Words 15 to 18 go to `sel[0..3]` (DS, SS, CS, ES).
  - Words 19 to 26 go to `gpr[0..7]` (DI, SI, BP, SP, BX, DX, CX, AX).
  - Words 0 to 2 and 4 to 10 are discarded.
- R5: Words 27 to 38 form four 3-word segment cache entries, for index e = 0..3 (ES, CS, SS, DS). In each entry:
  - The first word is base[15:0].
  - The second word's low byte is base[23:16] and its high byte is the access byte.
  - The third word is the limit (size minus one).
- R6: Words 39 to 50 form four 3-word table-register entries, for index e = 0..3 (global table, local-table cache, interrupt table, task-state cache). They use the same layout as R5, except that the high byte of the second word is a filler and is discarded.
- R7: `done` is high for exactly one cycle: the cycle after the 51st word is acknowledged. `fetch_addr` then equals the CS cache base (`seg_base[1]`) plus the zero-extended `ip`, modulo 2^24. The CS selector plays no part in it.
- R8: `intr_block` is high from the cycle after the trigger byte is taken through the `done` cycle, and low at all other times.
- R9: After reset, every register output, `mem_req`, `done` and `intr_block` are zero.
- R10: Outside a load, no loaded register changes, whatever the byte stream or memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction byte valid |
| op_byte | input | 8 | Instruction byte |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 24 | Byte address of requested word |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| intr_block | output | 1 | Interrupts held off |
| done | output | 1 | One-cycle load-complete pulse |
| fetch_addr | output | 24 | Resume address: CS cache base plus IP |
| msw | output | 4 | Machine status bits |
| task_reg | output | 16 | Task register selector |
| flags | output | 16 | Flag word |
| ip | output | 16 | Instruction pointer |
| ldt_sel | output | 16 | Local table selector |
| sel | output | 4x16 | Segment selectors DS, SS, CS, ES |
| gpr | output | 8x16 | DI, SI, BP, SP, BX, DX, CX, AX |
| seg_base | output | 4x24 | Segment cache bases ES, CS, SS, DS |
| seg_access | output | 4x8 | Segment cache access bytes |
| seg_limit | output | 4x16 | Segment cache limits |
| tbl_base | output | 4x24 | Table register bases |
| tbl_limit | output | 4x16 | Table register limits |

## Verification
Every cycle, the assertions check the shape of the read stream:
- addresses stay inside the table window and word-aligned;
- a request holds until acknowledged, and the address steps by two after each acknowledge;
- `done` follows the final acknowledge and lasts a single cycle;
- registers stay frozen while the block is idle.

The word-to-field mapping, the byte split of bases and access bytes, the discarded slots and filler bytes, address wrap in the resume address, and trigger rejection can only be shown by the bench's scenarios. These run loads under several acknowledge-stall rates with arithmetically generated tables.

// File: rtl/state_restore_seq.sv
module state_restore_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_byte,
  output logic              mem_req,
  output logic [23:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              intr_block,
  output logic              done,
  output logic [23:0]       fetch_addr,
  output logic [3:0]        msw,
  output logic [15:0]       task_reg,
  output logic [15:0]       flags,
  output logic [15:0]       ip,
  output logic [15:0]       ldt_sel,
  output logic [3:0][15:0]  sel,
  output logic [7:0][15:0]  gpr,
  output logic [3:0][23:0]  seg_base,
  output logic [3:0][7:0]   seg_access,
  output logic [3:0][15:0]  seg_limit,
  output logic [3:0][23:0]  tbl_base,
  output logic [3:0][15:0]  tbl_limit
);

  localparam logic [23:0] TABLE_BASE = 24'h000800;
  localparam int          WORDS      = 51;
  localparam int          IDX_W      = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(WORDS - 1);
  localparam logic [23:0] LAST_ADDR  = TABLE_BASE + 24'(2 * (WORDS - 1));
  localparam int W_MSW  = 3;
  localparam int W_TR   = 11;
  localparam int W_FLG  = 12;
  localparam int W_IP   = 13;
  localparam int W_LDT  = 14;
  localparam int W_SEL  = 15;
  localparam int W_GPR  = 19;
  localparam int W_SEGC = 27;
  localparam int W_TBLR = 39;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_FIN} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             saw_prefix;
  logic             wr;

  assign mem_req    = (state == S_LOAD);
  assign mem_addr   = TABLE_BASE + {{(23-IDX_W){1'b0}}, idx, 1'b0};
  assign intr_block = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign wr         = mem_req && mem_ack;
  assign fetch_addr = seg_base[1] + {8'h00, ip};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      saw_prefix <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (op_valid) begin
          if (saw_prefix && op_byte == 8'h05) begin
            state      <= S_LOAD;
            idx        <= '0;
            saw_prefix <= 1'b0;
          end else begin
            saw_prefix <= (op_byte == 8'h0F);
          end
        end
        S_LOAD: if (mem_ack) begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msw      <= '0;
      task_reg <= '0;
      flags    <= '0;
      ip       <= '0;
      ldt_sel  <= '0;
    end else if (wr) begin
      if (idx == IDX_W'(W_MSW)) msw      <= mem_rdata[3:0];
      if (idx == IDX_W'(W_TR))  task_reg <= mem_rdata;
      if (idx == IDX_W'(W_FLG)) flags    <= mem_rdata;
      if (idx == IDX_W'(W_IP))  ip       <= mem_rdata;
      if (idx == IDX_W'(W_LDT)) ldt_sel  <= mem_rdata;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n) sel[i] <= '0;
      else if (wr && idx == IDX_W'(W_SEL + i)) sel[i] <= mem_rdata;
    end
  end

  for (genvar i = 0; i < 8; i++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rst_n) gpr[i] <= '0;
      else if (wr && idx == IDX_W'(W_GPR + i)) gpr[i] <= mem_rdata;
    end
  end

  for (genvar e = 0; e < 4; e++) begin : g_cache
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_base[e]   <= '0;
        seg_access[e] <= '0;
        seg_limit[e]  <= '0;
        tbl_base[e]   <= '0;
        tbl_limit[e]  <= '0;
      end else if (wr) begin
        if (idx == IDX_W'(W_SEGC + 3*e))     seg_base[e][15:0]  <= mem_rdata;
        if (idx == IDX_W'(W_SEGC + 3*e + 1)) begin
          seg_base[e][23:16] <= mem_rdata[7:0];
          seg_access[e]      <= mem_rdata[15:8];
        end
        if (idx == IDX_W'(W_SEGC + 3*e + 2)) seg_limit[e]       <= mem_rdata;
        if (idx == IDX_W'(W_TBLR + 3*e))     tbl_base[e][15:0]  <= mem_rdata;
        if (idx == IDX_W'(W_TBLR + 3*e + 1)) tbl_base[e][23:16] <= mem_rdata[7:0];
        if (idx == IDX_W'(W_TBLR + 3*e + 2)) tbl_limit[e]       <= mem_rdata;
      end
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= TABLE_BASE && mem_addr <= LAST_ADDR && !mem_addr[0])); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_addr != LAST_ADDR) |=> (mem_req && mem_addr == $past(mem_addr) + 24'd2)); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack && mem_addr == LAST_ADDR)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !intr_block)); // R8
  AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> intr_block); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_block |=> $stable({ip, flags, msw, task_reg, seg_base, tbl_base, gpr})); // R10

endmodule

// File: tb/tb_state_restore_seq.sv
module tb_state_restore_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic mem_req, mem_ack, intr_block, done;
  logic [23:0] mem_addr, fetch_addr;
  logic [15:0] mem_rdata, task_reg, flags, ip, ldt_sel;
  logic [3:0] msw;
  logic [3:0][15:0] sel, seg_limit, tbl_limit;
  logic [7:0][15:0] gpr;
  logic [3:0][23:0] seg_base, tbl_base;
  logic [3:0][7:0] seg_access;

  int checks = 0, errors = 0;
  int cyc = 0, stall_cnt = 0, ap = 1, ack_cnt = 0, last_ack_cyc = -10;
  logic [15:0] tbl [0:50];

  always #2 clk = ~clk;

  state_restore_seq dut (.*);

  always @(posedge clk) begin cyc <= cyc + 1; stall_cnt <= stall_cnt + 1; end

  always_comb begin
    mem_ack = mem_req && ((stall_cnt % ap) == 0);
    if (mem_addr >= 24'h800 && mem_addr <= 24'h864) mem_rdata = tbl[(mem_addr - 24'h800) >> 1];
    else mem_rdata = 16'hDEAD;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_req && mem_ack) begin
    chk("R2 address order", mem_addr, 24'h800 + 24'(2 * ack_cnt));
    ack_cnt++;
    last_ack_cyc = cyc;
  end

  task automatic send(logic [7:0] b);
    @(negedge clk); op_valid = 1'b1; op_byte = b;
  endtask

  task automatic idle_bytes();
    @(negedge clk); op_valid = 1'b0;
  endtask

  task automatic check_fields();
    chk("R4 msw", msw, tbl[3][3:0]);
    chk("R4 task_reg", task_reg, tbl[11]);
    chk("R4 flags", flags, tbl[12]);
    chk("R4 ip", ip, tbl[13]);
    chk("R4 ldt_sel", ldt_sel, tbl[14]);
    for (int i = 0; i < 4; i++) chk("R4 selector", sel[i], tbl[15 + i]);
    for (int i = 0; i < 8; i++) chk("R4 gpr", gpr[i], tbl[19 + i]);
    for (int e = 0; e < 4; e++) begin
      chk("R5 seg base", seg_base[e], {tbl[28 + 3*e][7:0], tbl[27 + 3*e]});
      chk("R5 seg access", seg_access[e], tbl[28 + 3*e][15:8]);
      chk("R5 seg limit", seg_limit[e], tbl[29 + 3*e]);
      chk("R6 tbl base", tbl_base[e], {tbl[40 + 3*e][7:0], tbl[39 + 3*e]});
      chk("R6 tbl limit", tbl_limit[e], tbl[41 + 3*e]);
    end
    chk("R7 fetch_addr", fetch_addr,
        32'(24'({tbl[31][7:0], tbl[30]} + {8'h00, tbl[13]})));
  endtask

  task automatic run_load(int run, int period, bit inject);
    int k;
    for (int i = 0; i < 51; i++)
      tbl[i] = 16'((i * 32'h1357) ^ (run * 32'h2469) ^ 32'hA5C3);
    if (run == 3) begin
      tbl[30] = 16'hFFF0; tbl[31] = 16'h93FF; tbl[13] = 16'h0020; tbl[17] = 16'h1234;
    end
    ap = period;
    ack_cnt = 0;
    send(8'h0F); send(8'h05); idle_bytes();
    chk("R8 block after trigger", intr_block, 1);
    k = 0;
    while (!done && k < 2000) begin
      @(negedge clk); k++;
      if (inject && k == 5) begin op_valid = 1'b1; op_byte = 8'h0F; end
      if (inject && k == 6) op_byte = 8'h05;
      if (inject && k == 7) op_valid = 1'b0;
    end
    chk("R7 done seen", done, 1);
    chk("R7 done timing", cyc, last_ack_cyc + 1);
    chk("R2 word count", ack_cnt, 51);
    chk("R8 block at done", intr_block, 1);
    check_fields();
    if (run == 3) chk("R7 wrap fetch", fetch_addr, 24'h000010);
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
    chk("R8 block released", intr_block, 0);
    if (inject) begin
      repeat (6) @(negedge clk);
      chk("R1 bytes during load ignored", ack_cnt, 51);
      chk("R1 no second load", intr_block, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ip_hold;
    for (int i = 0; i < 51; i++) tbl[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 done", done, 0);
    chk("R9 mem_req", mem_req, 0);
    chk("R9 intr_block", intr_block, 0);
    chk("R9 msw", msw, 0);
    chk("R9 ip", ip, 0);
    chk("R9 seg_base", seg_base[1], 0);
    chk("R9 fetch_addr", fetch_addr, 0);

    run_load(0, 1, 1'b0);
    run_load(1, 2, 1'b0);
    run_load(2, 3, 1'b1);
    run_load(3, 1, 1'b0);

    ip_hold = ip;
    for (int i = 0; i < 51; i++) tbl[i] = 16'hBEEF;
    ack_cnt = 0;
    send(8'h0F); send(8'h33); send(8'h05); idle_bytes();
    repeat (4) @(negedge clk);
    chk("R1 broken pair", intr_block, 0);
    chk("R1 broken pair no reads", ack_cnt, 0);
    send(8'h05); idle_bytes();
    repeat (4) @(negedge clk);
    chk("R1 lone second byte", intr_block, 0);
    chk("R10 ip held", ip, ip_hold);
    chk("R10 flags held", flags, 16'((12 * 32'h1357) ^ (3 * 32'h2469) ^ 32'hA5C3));

    send(8'h0F); idle_bytes(); idle_bytes(); send(8'h05); idle_bytes();
    chk("R1 gap keeps pair", intr_block, 1);
    while (!done) @(negedge clk);
    check_fields();
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule